// File: doc/BRIEF.md
# Chip Erase Algorithm Sequencer

This block is a host-side controller. It runs the complete erase procedure of a byte-wide, command-driven flash memory on its own. A single `start` pulse launches the sequence. The controller first writes zero into every byte. Each byte is programmed with a setup command followed by the data write. After a settle delay, a program-verify command and a read-back confirm that the byte now holds 00h. Once the whole array holds zeros, the controller issues the two-write erase command and waits again. It then checks the array one byte at a time with the erase-verify command.

Whenever a byte does not read back as blank (FFh), the controller erases the array again. It then continues checking from that same byte, not from the start of the array. Two separate bounds stop the procedure. One limits program attempts per byte and the other limits the total number of erase operations. In every case the controller leaves the memory in read mode with a pair of reset writes. It then reports the result as a one-cycle `done` or `fail` pulse.

All memory strobes are registered and active low. Each bus write is a write-enable pulse inside a chip-enable window, with address and data held steady from before the falling edge until after the rising edge.

Top module: `erase_algo_seq`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it, the outputs `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 and `done` and `fail` are 0.
- R2: Before the first erase write, every byte in the array is programmed. Each byte gets a write of 40h, then a write of 00h at its address, then a write of C0h and a read that must return 00h. The total number of program data writes equals the array depth when no attempt fails.
- R3: A byte whose program-verify read is not 00h is programmed again. After PROG_MAX failed attempts on one byte the sequence ends with `fail`, and no erase command is issued.
- R4: An erase consists of two consecutive writes of 20h. At least WAIT_CYC clock cycles pass between the rising write-enable of the second 20h write and that of the next verify command. The same minimum gap applies between a program data write and its C0h write.
- R5: Each byte is verified by a write of A0h carrying the byte's address, followed by a read. A read of FFh advances to the next address. Passing the last address completes the sequence.
- R6: When an erase-verify read is not FFh, another erase is issued. The first verify after that erase uses the same address that failed.
- R7: When a verify read fails after ERASE_MAX erases have already been issued, the sequence ends with `fail` and no further erase is issued.
- R8: Every sequence ends with two consecutive writes of FFh. This is followed by exactly one single-cycle pulse on `done` for success or on `fail` for failure, never both.
- R9: `mem_we_n` is low only while `mem_ce_n` is low. It is never low together with `mem_oe_n`. `mem_addr` and `mem_wdata` do not change while `mem_we_n` is low, nor on the cycle it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the erase procedure when idle |
| mem_rdata | input | 8 | Data returned by the memory during a read strobe |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Byte address toward the memory |
| mem_wdata | output | 8 | Command or data byte toward the memory |
| done | output | 1 | One-cycle pulse: array verified blank |
| fail | output | 1 | One-cycle pulse: a retry bound was exceeded |

## Verification
Per-command effects are due as soon as the write-enable rises: the memory model in the bench samples the rising edge one clock later and updates its counters right away. The final outcome is due a fixed number of cycles after the second reset write completes. The bench therefore waits for the first `done` or `fail` pulse, sampling on the falling clock edge, and then lets 30 further cycles pass. Only after that does it compare pulse counts, command counts and ordering flags, so every counter has settled and any second pulse would already have been counted. Reset values are compared at the falling edge after the first rising edge that sees `rst`.

// File: rtl/erase_seq_pkg.sv
`timescale 1ns/1ps
package erase_seq_pkg;

  // Command bytes understood by the memory's command register
  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_PROG_CHECK = 8'hC0;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_ERASE_CHK  = 8'hA0;
  localparam logic [7:0] CMD_RESET      = 8'hFF;

  localparam logic [7:0] BYTE_CLEARED   = 8'h00;
  localparam logic [7:0] BYTE_BLANK     = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PG_SETUP,
    ST_PG_DATA,
    ST_PG_WAIT,
    ST_PG_VCMD,
    ST_PG_READ,
    ST_PG_CHECK,
    ST_ER_SETUP,
    ST_ER_GO,
    ST_ER_WAIT,
    ST_EV_CMD,
    ST_EV_READ,
    ST_EV_CHECK,
    ST_RS_FIRST,
    ST_RS_SECOND
  } seq_state_t;

  typedef enum logic [2:0] {
    BP_IDLE,
    BP_SETUP,
    BP_STROBE,
    BP_HOLD,
    BP_READ
  } bus_phase_t;

endpackage

// File: rtl/flash_bus_cycle.sv
`timescale 1ns/1ps
// Turns one request into a complete memory bus cycle with registered strobes.
module flash_bus_cycle
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STROBE_CYC = 2,
  parameter int READ_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [7:0]        rd_in,
  output logic              ack,
  output logic [7:0]        rdata_q,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);

  localparam int LONGEST = (STROBE_CYC > READ_CYC) ? STROBE_CYC : READ_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LAST   = CNT_W'(READ_CYC - 1);

  bus_phase_t       phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= BP_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      addr_o  <= '0;
      data_o  <= '0;
      ack     <= 1'b0;
      rdata_q <= '0;
      cnt     <= '0;
    end else begin
      ack <= 1'b0;
      case (phase)
        BP_IDLE: begin
          // ack high means the requester has not yet moved past the last cycle
          if (req && !ack) begin
            addr_o <= req_addr;
            ce_n   <= 1'b0;
            if (req_rd) begin
              data_o <= '0;
              oe_n   <= 1'b0;
              cnt    <= READ_LAST;
              phase  <= BP_READ;
            end else begin
              data_o <= req_data;
              phase  <= BP_SETUP;
            end
          end
        end
        BP_SETUP: begin
          we_n  <= 1'b0;
          cnt   <= STROBE_LAST;
          phase <= BP_STROBE;
        end
        BP_STROBE: begin
          if (cnt == '0) begin
            we_n  <= 1'b1;
            phase <= BP_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BP_HOLD: begin
          ce_n  <= 1'b1;
          ack   <= 1'b1;
          phase <= BP_IDLE;
        end
        BP_READ: begin
          if (cnt == '0) begin
            rdata_q <= rd_in;
            oe_n    <= 1'b1;
            ce_n    <= 1'b1;
            ack     <= 1'b1;
            phase   <= BP_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= BP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wait_timer.sv
`timescale 1ns/1ps
// Down-counter that reports zero after a load of WAIT_CYC.
module wait_timer #(
  parameter int WAIT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int TW = $clog2(WAIT_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(WAIT_CYC);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/erase_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencing FSM: pre-program, erase, verify with resume, reset pair.
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int ERASE_MAX = 4,
  parameter int PROG_MAX  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  input  logic              tmr_expired,
  output logic              bus_req,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_data,
  output logic              tmr_load,
  output logic              done,
  output logic              fail
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam int EW = $clog2(ERASE_MAX + 1);
  localparam int PW = $clog2(PROG_MAX + 1);
  localparam logic [EW-1:0] ERASE_LIMIT = EW'(ERASE_MAX);
  localparam logic [PW-1:0] PROG_LIMIT  = PW'(PROG_MAX);

  seq_state_t        state;
  logic [ADDR_W-1:0] addr_q;
  logic [EW-1:0]     erases_q;
  logic [PW-1:0]     tries_q;
  logic              fail_pend;

  // Bus request decode: one bus operation per bus state
  always_comb begin
    bus_req  = 1'b1;
    bus_rd   = 1'b0;
    bus_addr = addr_q;
    bus_data = CMD_RESET;
    case (state)
      ST_PG_SETUP:  bus_data = CMD_PROG_SETUP;
      ST_PG_DATA:   bus_data = BYTE_CLEARED;
      ST_PG_VCMD:   bus_data = CMD_PROG_CHECK;
      ST_PG_READ:   bus_rd   = 1'b1;
      ST_ER_SETUP:  bus_data = CMD_ERASE;
      ST_ER_GO:     bus_data = CMD_ERASE;
      ST_EV_CMD:    bus_data = CMD_ERASE_CHK;
      ST_EV_READ:   bus_rd   = 1'b1;
      ST_RS_FIRST:  bus_data = CMD_RESET;
      ST_RS_SECOND: bus_data = CMD_RESET;
      default:      bus_req  = 1'b0;
    endcase
  end

  assign tmr_load = bus_ack && ((state == ST_PG_DATA) || (state == ST_ER_GO));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      erases_q  <= '0;
      tries_q   <= '0;
      fail_pend <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            addr_q    <= '0;
            erases_q  <= '0;
            tries_q   <= '0;
            fail_pend <= 1'b0;
            state     <= ST_PG_SETUP;
          end
        end
        ST_PG_SETUP: if (bus_ack) state <= ST_PG_DATA;
        ST_PG_DATA: begin
          if (bus_ack) begin
            tries_q <= tries_q + 1'b1;
            state   <= ST_PG_WAIT;
          end
        end
        ST_PG_WAIT:  if (tmr_expired) state <= ST_PG_VCMD;
        ST_PG_VCMD:  if (bus_ack) state <= ST_PG_READ;
        ST_PG_READ:  if (bus_ack) state <= ST_PG_CHECK;
        ST_PG_CHECK: begin
          if (bus_rdata == BYTE_CLEARED) begin
            tries_q <= '0;
            if (addr_q == LAST_ADDR) begin
              addr_q <= '0;
              state  <= ST_ER_SETUP;
            end else begin
              addr_q <= addr_q + 1'b1;
              state  <= ST_PG_SETUP;
            end
          end else if (tries_q >= PROG_LIMIT) begin
            fail_pend <= 1'b1;
            state     <= ST_RS_FIRST;
          end else begin
            state <= ST_PG_SETUP;
          end
        end
        ST_ER_SETUP: if (bus_ack) state <= ST_ER_GO;
        ST_ER_GO: begin
          if (bus_ack) begin
            erases_q <= erases_q + 1'b1;
            state    <= ST_ER_WAIT;
          end
        end
        ST_ER_WAIT:  if (tmr_expired) state <= ST_EV_CMD;
        ST_EV_CMD:   if (bus_ack) state <= ST_EV_READ;
        ST_EV_READ:  if (bus_ack) state <= ST_EV_CHECK;
        ST_EV_CHECK: begin
          if (bus_rdata == BYTE_BLANK) begin
            if (addr_q == LAST_ADDR) begin
              state <= ST_RS_FIRST;
            end else begin
              addr_q <= addr_q + 1'b1;
              state  <= ST_EV_CMD;
            end
          end else if (erases_q >= ERASE_LIMIT) begin
            fail_pend <= 1'b1;
            state     <= ST_RS_FIRST;
          end else begin
            // address kept: checking resumes at the failing byte
            state <= ST_ER_SETUP;
          end
        end
        ST_RS_FIRST: if (bus_ack) state <= ST_RS_SECOND;
        ST_RS_SECOND: begin
          if (bus_ack) begin
            done  <= !fail_pend;
            fail  <= fail_pend;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/erase_algo_seq.sv
`timescale 1ns/1ps
module erase_algo_seq #(
  parameter int ADDR_W     = 4,
  parameter int WAIT_CYC   = 8,
  parameter int ERASE_MAX  = 4,
  parameter int PROG_MAX   = 3,
  parameter int STROBE_CYC = 2,
  parameter int READ_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              done,
  output logic              fail
);

  logic              bus_req;
  logic              bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_data;
  logic              bus_ack;
  logic [7:0]        bus_rdata;
  logic              tmr_load;
  logic              tmr_expired;

  erase_seq_ctrl #(
    .ADDR_W    (ADDR_W),
    .ERASE_MAX (ERASE_MAX),
    .PROG_MAX  (PROG_MAX)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .tmr_expired (tmr_expired),
    .bus_req     (bus_req),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .tmr_load    (tmr_load),
    .done        (done),
    .fail        (fail)
  );

  flash_bus_cycle #(
    .ADDR_W     (ADDR_W),
    .STROBE_CYC (STROBE_CYC),
    .READ_CYC   (READ_CYC)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .req      (bus_req),
    .req_rd   (bus_rd),
    .req_addr (bus_addr),
    .req_data (bus_data),
    .rd_in    (mem_rdata),
    .ack      (bus_ack),
    .rdata_q  (bus_rdata),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .addr_o   (mem_addr),
    .data_o   (mem_wdata)
  );

  wait_timer #(
    .WAIT_CYC (WAIT_CYC)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_expired)
  );

endmodule

// File: rtl/erase_algo_seq_chk.sv
`timescale 1ns/1ps
module erase_algo_seq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              done,
  input logic              fail
);

  a_r9_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  a_r9_no_strobe_clash: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  a_r9_steady_while_low: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_wdata)));

  a_r9_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_fail_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);

  a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  a_r8_bus_idle_at_report: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

bind erase_algo_seq erase_algo_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .fail      (fail)
);

// File: tb/tb_erase_algo_seq.sv
`timescale 1ns/1ps
module tb_erase_algo_seq;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int WAITC = 8;
  localparam int EMAX  = 4;
  localparam int PMAX  = 3;
  localparam int RUN_LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    mem_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          done, fail;

  always #2 clk = ~clk;

  erase_algo_seq #(
    .ADDR_W(AW), .WAIT_CYC(WAITC), .ERASE_MAX(EMAX), .PROG_MAX(PMAX),
    .STROBE_CYC(2), .READ_CYC(2)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .mem_rdata(mem_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .fail(fail)
  );

  // Scenario: stubborn byte (address, erases it needs), weak byte (address, failed
  // program attempts), expected fail flag, erases, program writes, verify commands
  typedef struct packed {
    logic [3:0] sa;
    logic [3:0] sn;
    logic [3:0] pa;
    logic [3:0] pf;
    logic       ef;
    logic [7:0] ee;
    logic [7:0] ep;
    logic [7:0] ev;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  4'd1, 4'd0, 4'd0, 1'b0, 8'd1, 8'd16, 8'd16},
    '{4'd5,  4'd3, 4'd0, 4'd0, 1'b0, 8'd3, 8'd16, 8'd18},
    '{4'd15, 4'd2, 4'd0, 4'd0, 1'b0, 8'd2, 8'd16, 8'd17},
    '{4'd0,  4'd4, 4'd0, 4'd0, 1'b0, 8'd4, 8'd16, 8'd19},
    '{4'd7,  4'd5, 4'd0, 4'd0, 1'b1, 8'd4, 8'd16, 8'd11},
    '{4'd0,  4'd1, 4'd3, 4'd2, 1'b0, 8'd1, 8'd18, 8'd16},
    '{4'd0,  4'd1, 4'd9, 4'd3, 1'b1, 8'd0, 8'd12, 8'd0}
  };

  // Model configuration, written by the stimulus only
  logic [3:0] cfg_sa = 4'd0, cfg_pa = 4'd0;
  int         cfg_sn = 1,    cfg_pf = 0;

  // Behavioural memory model and observation counters
  logic [7:0]    fm [DEPTH];
  int            n_er, n_pg, n_ev, n_done, n_fail;
  int            resume_bad, preprog_bad, gap_bad, bus_bad, pf_left;
  int            cyc = 0, t_mark;
  logic [15:0]   last2;
  int            mode;  // 0 array read, 1 program check, 2 erase check
  int            pend;  // 0 none, 1 program data next, 2 second erase write next
  logic [AW-1:0] vaddr, lastprog, lastfail, addr_d;
  logic [7:0]    data_d;
  logic          we_d, after_erase;

  function automatic int need_of(input int i);
    return (i == int'(cfg_sa)) ? cfg_sn : 1;
  endfunction

  assign mem_rdata = (mode == 2) ? fm[vaddr] : (mode == 1) ? fm[lastprog] : fm[mem_addr];

  always @(posedge clk) begin
    int bad;
    int e;
    cyc    <= cyc + 1;
    we_d   <= mem_we_n;
    addr_d <= mem_addr;
    data_d <= mem_wdata;
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) fm[i] <= 8'h5A + 8'(i);
      n_er <= 0; n_pg <= 0; n_ev <= 0; n_done <= 0; n_fail <= 0;
      resume_bad <= 0; preprog_bad <= 0; gap_bad <= 0; bus_bad <= 0;
      pf_left <= cfg_pf; t_mark <= 0; last2 <= 16'h0000;
      mode <= 0; pend <= 0; vaddr <= '0; lastprog <= '0; lastfail <= '0;
      after_erase <= 1'b0;
    end else begin
      if (done) n_done <= n_done + 1;
      if (fail) n_fail <= n_fail + 1;
      // R9 bus discipline as seen from the memory side
      if ((mem_we_n === 1'b0) && (mem_ce_n !== 1'b0)) bus_bad <= bus_bad + 1;
      if ((mem_we_n === 1'b0) && (mem_oe_n === 1'b0)) bus_bad <= bus_bad + 1;
      if ((we_d === 1'b0) && ((mem_addr !== addr_d) || (mem_wdata !== data_d)))
        bus_bad <= bus_bad + 1;
      // A write is taken on the rising write enable
      if ((we_d === 1'b0) && (mem_we_n === 1'b1) && (mem_ce_n === 1'b0)) begin
        last2 <= {last2[7:0], mem_wdata};
        if (pend == 1) begin
          n_pg <= n_pg + 1;
          if ((mem_addr == cfg_pa) && (pf_left > 0)) pf_left <= pf_left - 1;
          else fm[mem_addr] <= fm[mem_addr] & mem_wdata;
          lastprog <= mem_addr;
          pend <= 0; mode <= 0; t_mark <= cyc;
        end else if (pend == 2) begin
          pend <= 0;
          if (mem_wdata == 8'h20) begin
            e = n_er + 1;
            n_er <= e;
            bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
              if (fm[i] != 8'h00) bad++;
              if (e >= need_of(i)) fm[i] <= 8'hFF;
            end
            if (n_er == 0) preprog_bad <= preprog_bad + bad;
            after_erase <= 1'b1;
            t_mark <= cyc;
          end
        end else begin
          case (mem_wdata)
            8'h40: pend <= 1;
            8'h20: pend <= 2;
            8'hA0: begin
              n_ev <= n_ev + 1;
              vaddr <= mem_addr;
              mode <= 2;
              if (after_erase && (cyc - t_mark < WAITC)) gap_bad <= gap_bad + 1;
              if (after_erase && (n_er > 1) && (mem_addr != lastfail))
                resume_bad <= resume_bad + 1;
              after_erase <= 1'b0;
              if (fm[mem_addr] != 8'hFF) lastfail <= mem_addr;
            end
            8'hC0: begin
              mode <= 1;
              if (cyc - t_mark < WAITC) gap_bad <= gap_bad + 1;
            end
            8'hFF, 8'h00: mode <= 0;
            default: ;
          endcase
        end
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_to_end(input string tag);
    int waited;
    waited = 0;
    while ((n_done + n_fail == 0) && (waited < RUN_LIMIT)) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= RUN_LIMIT) chk({tag, " watchdog (run never ended)"}, 1, 0);
    repeat (30) @(negedge clk);
  endtask

  task automatic check_vector(input vec_t v, input int idx);
    string s;
    s = $sformatf("vec%0d", idx);
    chk({s, " R8 done pulses"}, n_done, v.ef ? 0 : 1);
    chk({s, " R7 R3 fail pulses"}, n_fail, v.ef ? 1 : 0);
    chk({s, " R4 erase operations"}, n_er, int'(v.ee));
    chk({s, " R2 R3 program data writes"}, n_pg, int'(v.ep));
    chk({s, " R5 erase-verify commands"}, n_ev, int'(v.ev));
    chk({s, " R6 resume address mismatches"}, resume_bad, 0);
    chk({s, " R2 bytes not zero at first erase"}, preprog_bad, 0);
    chk({s, " R4 short settle gaps"}, gap_bad, 0);
    chk({s, " R8 final two writes FFh"}, int'(last2), 16'hFFFF);
    chk({s, " R9 bus strobe violations"}, bus_bad, 0);
  endtask

  initial begin
    // R1: outputs after the first edge that samples reset
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset strobes and flags", int'({mem_ce_n, mem_oe_n, mem_we_n, done, fail}), 5'b11100);
    do_reset();

    // Scenario table
    for (int k = 0; k < NVEC; k++) begin
      cfg_sa = VECS[k].sa;
      cfg_sn = int'(VECS[k].sn);
      cfg_pa = VECS[k].pa;
      cfg_pf = int'(VECS[k].pf);
      do_reset();
      launch();
      run_to_end($sformatf("vec%0d", k));
      check_vector(VECS[k], k);
    end

    // Directed: reset in the middle of a run returns the block to idle
    cfg_sa = 4'd0; cfg_sn = 1; cfg_pa = 4'd0; cfg_pf = 0;
    do_reset();
    launch();
    repeat (150) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset strobes and flags", int'({mem_ce_n, mem_oe_n, mem_we_n, done, fail}), 5'b11100);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk("R1 no activity without start", int'({mem_ce_n, done, fail}), 3'b100);

    // Directed: fresh run after abort, stubborn last-but-one byte
    cfg_sa = 4'd14; cfg_sn = 3;
    do_reset();
    launch();
    run_to_end("restart");
    chk("R6 restart verify commands", n_ev, 18);
    chk("R6 restart resume mismatches", resume_bad, 0);
    chk("R5 restart done pulses", n_done, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #790000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule